// File: doc/BRIEF.md
# Two-Slot Write-Through Integer Register File

This block is the integer register file for a pipeline that handles two instructions per cycle. It holds 32 registers of 32 bits in plain flip-flops. Four read ports return data combinationally and can all be used in the same cycle. Two write ports carry results from the two instructions in flight.

The two write slots are ordered. Slot 1 counts as the earlier instruction and slot 2 as the later one. A read in the same cycle as a write sees the value being written. The forwarding comes from the two write-port inputs only, not from extra ports on every entry. Values are copied into the array at the rising clock edge. Register 0 is hard-wired to zero.

A decode pair uses the file as follows. The first instruction's result on slot 1 is already visible to the second instruction's operand reads. When both slots name the same register, slot 2 wins.

Top module: `dwrf_top`

## Requirements
- R1: An active-high synchronous reset sets every register to zero. After reset, every read port returns 0 for every index.
- R2: The four read ports are independent and combinational. Each returns the value selected by its own index in the same cycle, with no ordering among them.
- R3: A write with its enable high is committed at the rising clock edge. The value is returned by any read of that index from the next cycle on, until a later write to that index.
- R4: A read whose index matches an enabled slot 2 write in the same cycle returns the slot 2 write data.
- R5: A read whose index matches an enabled slot 1 write, and no enabled slot 2 write, returns the slot 1 write data in that same cycle.
- R6: When both slots are enabled and target the same register, the slot 2 data is returned by same-cycle reads and is the value stored at the edge.
- R7: Index 0 always reads as 0. A write to index 0 on either slot is discarded and is never forwarded.
- R8: A write slot whose enable is low changes no register and forwards nothing.
- R9: A register that no enabled write targets keeps its value across clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| wr1_en | input | 1 | Write slot 1 enable (earlier instruction) |
| wr1_idx | input | 5 | Write slot 1 register index |
| wr1_data | input | 32 | Write slot 1 data |
| wr2_en | input | 1 | Write slot 2 enable (later instruction) |
| wr2_idx | input | 5 | Write slot 2 register index |
| wr2_data | input | 32 | Write slot 2 data |
| rd_idx | input | 4x5 | Register index of each read port; element k drives port k |
| rd_data | output | 4x32 | Combinational read data of each read port |

## Verification
A wrong forwarding priority shows up at once: a read that matches both slots returns slot 1 data in the same cycle. A wrong commit order stays hidden until the next cycle, when a plain array read returns the earlier slot's value. A broken zero rule or a leaking disabled slot corrupts a read at index 0, or at the targeted index, in the write cycle or the one after it. The bench reads every port against a reference array on every cycle, so any of these faults is caught within one cycle of the stimulus that causes it.

// File: rtl/dwrf_pkg.sv
package dwrf_pkg;

    localparam int DEF_XLEN  = 32;
    localparam int DEF_NREGS = 32;
    localparam int DEF_NRD   = 4;

    // Where a read port takes its value from
    typedef enum logic [1:0] {
        SRC_ARRAY = 2'd0,
        SRC_SLOT1 = 2'd1,
        SRC_SLOT2 = 2'd2,
        SRC_ZERO  = 2'd3
    } byp_src_e;

    // Later slot outranks earlier slot, which outranks storage
    function automatic byp_src_e pick_src(input logic is_zero,
                                          input logic hit2,
                                          input logic hit1);
        if (is_zero)   return SRC_ZERO;
        else if (hit2) return SRC_SLOT2;
        else if (hit1) return SRC_SLOT1;
        else           return SRC_ARRAY;
    endfunction

endpackage

// File: rtl/rf_write_gate.sv
module rf_write_gate #(
    parameter int XLEN  = 32,
    parameter int IDX_W = 5
) (
    input  logic             in_en,
    input  logic [IDX_W-1:0] in_idx,
    input  logic [XLEN-1:0]  in_data,
    output logic             out_en,
    output logic [IDX_W-1:0] out_idx,
    output logic [XLEN-1:0]  out_data
);
    // Writes aimed at the zero register are dropped before storage and forwarding
    always_comb begin
        out_en   = in_en && (in_idx != '0);
        out_idx  = in_idx;
        out_data = in_data;
    end
endmodule

// File: rtl/rf_storage.sv
module rf_storage #(
    parameter int XLEN  = 32,
    parameter int NREGS = 32,
    localparam int IDX_W = $clog2(NREGS)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        s1_en,
    input  logic [IDX_W-1:0]            s1_idx,
    input  logic [XLEN-1:0]             s1_data,
    input  logic                        s2_en,
    input  logic [IDX_W-1:0]            s2_idx,
    input  logic [XLEN-1:0]             s2_data,
    output logic [NREGS-1:0][XLEN-1:0]  regs
);
    assign regs[0] = '0;

    for (genvar i = 1; i < NREGS; i++) begin : g_entry
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(i);
        logic [XLEN-1:0] q;

        // Slot 2 is the later write, so it is checked first
        always_ff @(posedge clk) begin
            if (rst)
                q <= '0;
            else if (s2_en && s2_idx == MY_IDX)
                q <= s2_data;
            else if (s1_en && s1_idx == MY_IDX)
                q <= s1_data;
        end

        assign regs[i] = q;
    end
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port #(
    parameter int XLEN  = 32,
    parameter int NREGS = 32,
    localparam int IDX_W = $clog2(NREGS)
) (
    input  logic [IDX_W-1:0]            rd_idx,
    input  logic [NREGS-1:0][XLEN-1:0]  regs,
    input  logic                        s1_en,
    input  logic [IDX_W-1:0]            s1_idx,
    input  logic [XLEN-1:0]             s1_data,
    input  logic                        s2_en,
    input  logic [IDX_W-1:0]            s2_idx,
    input  logic [XLEN-1:0]             s2_data,
    output logic [XLEN-1:0]             rd_data
);
    import dwrf_pkg::*;

    byp_src_e src;

    always_comb begin
        src = pick_src(rd_idx == '0,
                       s2_en && (s2_idx == rd_idx),
                       s1_en && (s1_idx == rd_idx));
        unique case (src)
            SRC_SLOT2: rd_data = s2_data;
            SRC_SLOT1: rd_data = s1_data;
            SRC_ARRAY: rd_data = regs[rd_idx];
            default:   rd_data = '0;
        endcase
    end
endmodule

// File: rtl/dwrf_top.sv
module dwrf_top #(
    parameter int XLEN  = dwrf_pkg::DEF_XLEN,
    parameter int NREGS = dwrf_pkg::DEF_NREGS,
    parameter int NRD   = dwrf_pkg::DEF_NRD,
    localparam int IDX_W = $clog2(NREGS)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr1_en,
    input  logic [IDX_W-1:0]          wr1_idx,
    input  logic [XLEN-1:0]           wr1_data,
    input  logic                      wr2_en,
    input  logic [IDX_W-1:0]          wr2_idx,
    input  logic [XLEN-1:0]           wr2_data,
    input  logic [NRD-1:0][IDX_W-1:0] rd_idx,
    output logic [NRD-1:0][XLEN-1:0]  rd_data
);
    logic             g1_en, g2_en;
    logic [IDX_W-1:0] g1_idx, g2_idx;
    logic [XLEN-1:0]  g1_data, g2_data;
    logic [NREGS-1:0][XLEN-1:0] regs;

    rf_write_gate #(.XLEN(XLEN), .IDX_W(IDX_W)) u_gate1 (
        .in_en(wr1_en), .in_idx(wr1_idx), .in_data(wr1_data),
        .out_en(g1_en), .out_idx(g1_idx), .out_data(g1_data)
    );

    rf_write_gate #(.XLEN(XLEN), .IDX_W(IDX_W)) u_gate2 (
        .in_en(wr2_en), .in_idx(wr2_idx), .in_data(wr2_data),
        .out_en(g2_en), .out_idx(g2_idx), .out_data(g2_data)
    );

    rf_storage #(.XLEN(XLEN), .NREGS(NREGS)) u_store (
        .clk(clk), .rst(rst),
        .s1_en(g1_en), .s1_idx(g1_idx), .s1_data(g1_data),
        .s2_en(g2_en), .s2_idx(g2_idx), .s2_data(g2_data),
        .regs(regs)
    );

    for (genvar k = 0; k < NRD; k++) begin : g_rd
        rf_read_port #(.XLEN(XLEN), .NREGS(NREGS)) u_rd (
            .rd_idx(rd_idx[k]), .regs(regs),
            .s1_en(g1_en), .s1_idx(g1_idx), .s1_data(g1_data),
            .s2_en(g2_en), .s2_idx(g2_idx), .s2_data(g2_data),
            .rd_data(rd_data[k])
        );
    end
endmodule

// File: rtl/dwrf_checker.sv
module dwrf_checker #(
    parameter int XLEN  = 32,
    parameter int NREGS = 32,
    parameter int NRD   = 4,
    localparam int IDX_W = $clog2(NREGS)
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      wr1_en,
    input logic [IDX_W-1:0]          wr1_idx,
    input logic [XLEN-1:0]           wr1_data,
    input logic                      wr2_en,
    input logic [IDX_W-1:0]          wr2_idx,
    input logic [XLEN-1:0]           wr2_data,
    input logic [NRD-1:0][IDX_W-1:0] rd_idx,
    input logic [NRD-1:0][XLEN-1:0]  rd_data
);
    for (genvar k = 0; k < NRD; k++) begin : g_chk
        logic hit;
        assign hit = (wr1_en && wr1_idx == rd_idx[k]) || (wr2_en && wr2_idx == rd_idx[k]);

        // R7: index zero reads zero
        p_zero_reads_r7: assert property (@(posedge clk) disable iff (rst)
            (rd_idx[k] == '0) |-> (rd_data[k] == '0));

        // R4 and R6: slot 2 forwards
        p_slot2_fwd_r4: assert property (@(posedge clk) disable iff (rst)
            (wr2_en && wr2_idx != '0 && wr2_idx == rd_idx[k]) |-> (rd_data[k] == wr2_data));

        // R5: slot 1 forwards when slot 2 misses
        p_slot1_fwd_r5: assert property (@(posedge clk) disable iff (rst)
            (wr1_en && wr1_idx != '0 && wr1_idx == rd_idx[k]
             && !(wr2_en && wr2_idx == rd_idx[k])) |-> (rd_data[k] == wr1_data));

        // R9: untouched register keeps its value
        p_hold_r9: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $stable(rd_idx[k]) && !hit && !$past(hit)) |-> $stable(rd_data[k]));
    end
endmodule

bind dwrf_top dwrf_checker #(.XLEN(XLEN), .NREGS(NREGS), .NRD(NRD)) u_chk (
    .clk(clk), .rst(rst),
    .wr1_en(wr1_en), .wr1_idx(wr1_idx), .wr1_data(wr1_data),
    .wr2_en(wr2_en), .wr2_idx(wr2_idx), .wr2_data(wr2_data),
    .rd_idx(rd_idx), .rd_data(rd_data)
);

// File: tb/dwrf_top_test.sv
module dwrf_top_test;
    localparam int XLEN = 32, NREGS = 32, NRD = 4, IW = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr1_en = 0, wr2_en = 0;
    logic [IW-1:0] wr1_idx = '0, wr2_idx = '0;
    logic [XLEN-1:0] wr1_data = '0, wr2_data = '0;
    logic [NRD-1:0][IW-1:0] rd_idx = '0;
    logic [NRD-1:0][XLEN-1:0] rd_data;

    int n_tests = 0, n_fail = 0;
    logic [XLEN-1:0] model [NREGS];

    always #4 clk = ~clk;

    dwrf_top uut (
        .clk(clk), .rst(rst),
        .wr1_en(wr1_en), .wr1_idx(wr1_idx), .wr1_data(wr1_data),
        .wr2_en(wr2_en), .wr2_idx(wr2_idx), .wr2_data(wr2_data),
        .rd_idx(rd_idx), .rd_data(rd_data)
    );

    function automatic logic [XLEN-1:0] expect_rd(input logic [IW-1:0] r);
        if (r == 0) return '0;
        if (wr2_en && wr2_idx == r) return wr2_data;
        if (wr1_en && wr1_idx == r) return wr1_data;
        return model[r];
    endfunction

    task automatic chk(input string tag, input logic [XLEN-1:0] got, input logic [XLEN-1:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Drive one cycle at the falling edge, check all ports, then commit at the rising edge
    task automatic step(input string tag,
                        input logic e1, input logic [IW-1:0] i1, input logic [XLEN-1:0] d1,
                        input logic e2, input logic [IW-1:0] i2, input logic [XLEN-1:0] d2,
                        input logic [NRD-1:0][IW-1:0] rds);
        @(negedge clk);
        wr1_en = e1; wr1_idx = i1; wr1_data = d1;
        wr2_en = e2; wr2_idx = i2; wr2_data = d2;
        rd_idx = rds;
        #1;
        for (int k = 0; k < NRD; k++) chk(tag, rd_data[k], expect_rd(rds[k]));
        @(posedge clk);
        if (e1 && i1 != 0) model[i1] = d1;
        if (e2 && i2 != 0) model[i2] = d2;
    endtask

    task automatic t_reset;   // R1
        for (int b = 0; b < NREGS; b += NRD)
            step("R1 reset zero", 0, 0, 0, 0, 0, 0,
                 {IW'(b+3), IW'(b+2), IW'(b+1), IW'(b)});
    endtask

    task automatic t_commit;  // R3, R2
        step("R3 write", 1, 5, 32'hAAAA_0005, 1, 9, 32'h9999_0009, {5'd0, 5'd1, 5'd2, 5'd3});
        step("R3 readback", 0, 0, 0, 0, 0, 0, {5'd9, 5'd5, 5'd9, 5'd5});
        step("R2 mixed ports", 1, 7, 32'h7777_0007, 0, 0, 0, {5'd5, 5'd9, 5'd0, 5'd12});
        step("R2 independent", 0, 0, 0, 0, 0, 0, {5'd7, 5'd12, 5'd5, 5'd9});
    endtask

    task automatic t_bypass;  // R4, R5
        step("R4 slot2 fwd", 0, 0, 0, 1, 11, 32'hB0B0_0011, {5'd11, 5'd5, 5'd11, 5'd7});
        step("R5 slot1 fwd", 1, 12, 32'hC1C1_0012, 1, 13, 32'hD2D2_0013, {5'd12, 5'd13, 5'd11, 5'd12});
        step("R5 slot1 to slot2 reader", 1, 14, 32'h1414_1414, 0, 0, 0, {5'd14, 5'd14, 5'd13, 5'd12});
    endtask

    task automatic t_collide; // R6
        step("R6 collision fwd", 1, 20, 32'h1111_0020, 1, 20, 32'h2222_0020, {5'd20, 5'd20, 5'd0, 5'd14});
        step("R6 collision stored", 0, 0, 0, 0, 0, 0, {5'd20, 5'd19, 5'd21, 5'd20});
    endtask

    task automatic t_zero;    // R7
        step("R7 x0 write", 1, 0, 32'hDEAD_BEEF, 1, 0, 32'hFEED_FACE, {5'd0, 5'd0, 5'd0, 5'd0});
        step("R7 x0 after", 1, 0, 32'h1234_5678, 0, 0, 0, {5'd0, 5'd20, 5'd0, 5'd5});
    endtask

    task automatic t_disabled; // R8, R9
        step("R8 disabled slots", 0, 5, 32'hBAD0_0001, 0, 9, 32'hBAD0_0002, {5'd5, 5'd9, 5'd5, 5'd9});
        step("R8 disabled after", 0, 0, 0, 0, 0, 0, {5'd5, 5'd9, 5'd7, 5'd11});
        step("R9 retention", 1, 30, 32'h3030_3030, 1, 31, 32'h3131_3131, {5'd5, 5'd20, 5'd12, 5'd13});
        step("R9 retention after", 0, 0, 0, 0, 0, 0, {5'd30, 5'd31, 5'd5, 5'd20});
    endtask

    task automatic t_random;  // R2..R9 mixed traffic with collisions
        for (int n = 0; n < 400; n++) begin
            logic [IW-1:0] i1, i2;
            logic [NRD-1:0][IW-1:0] rds;
            i1 = (n % 3 == 0) ? IW'($urandom_range(0, 3)) : IW'($urandom);
            i2 = (n % 4 == 0) ? i1 : ((n % 3 == 0) ? IW'($urandom_range(0, 3)) : IW'($urandom));
            for (int k = 0; k < NRD; k++)
                rds[k] = (k == 0) ? i1 : ((k == 1) ? i2 : IW'($urandom));
            step("R4 R5 R6 R9 random", 1'($urandom), i1, $urandom, 1'($urandom), i2, $urandom, rds);
        end
    endtask

    initial begin
        for (int r = 0; r < NREGS; r++) model[r] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_commit();
        t_bypass();
        t_collide();
        t_zero();
        t_disabled();
        t_random();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule